// File: doc/BRIEF.md
# Serial DAC Code Receiver

This block is the digital front end of a serial-loaded ten-bit DAC, rebuilt as synchronous logic that runs on a fast system clock. A host drives an active-low select, a serial clock and a data line. While the select is low, every rising serial clock edge moves one data bit into a sixteen-bit shift register, most significant bit first. When the select returns high, the block lifts the ten-bit code out of the register and places it in a holding register. That holding register drives the parallel output, and a one-cycle strobe marks each new value.

The code always sits just above the two trailing sub-LSB bits. A twelve-bit frame therefore decodes the same way as a sixteen-bit frame that carries four leading dummy bits. The serial inputs are asynchronous to the system clock. They pass through a multi-stage synchronizer before any edge is detected, so the serial clock must be several times slower than the system clock. The block can act as a bench responder or stand in for the converter inside a programmable-logic design.

Top module: `sdac_rx`

## Requirements
- R1: While reset is asserted and after it is released, `code_o` is 0 and `update_o` is 0 until the first completed frame.
- R2: While `cs_n_i` is low, each rising edge of `sclk_i` shifts `sdi_i` into the shift register at bit 0, so the first bit sent ends up most significant. For a 12-bit frame, `code_o` takes the first ten bits sent.
- R3: A 16-bit frame whose four leading bits are dummies yields the same `code_o` as the 12-bit frame made of its last twelve bits. The dummy values have no effect.
- R4: The last two bits of a frame (register bits [1:0]) never appear in `code_o`. The code is register bits [11:2].
- R5: Rising edges of `sclk_i` while `cs_n_i` is high change neither `code_o` nor the strobe count.
- R6: A falling edge of `cs_n_i` clears the shift register. A frame of fewer than twelve bits therefore decodes as if it were preceded by zeros. For example, five 1 bits give code 7.
- R7: `code_o` changes only on a rising edge of `cs_n_i`. Mid-frame it keeps the previous code.
- R8: Each rising edge of `cs_n_i` produces exactly one `update_o` pulse, one system clock wide. The pulse appears in the same cycle as the new `code_o`.
- R9: In a frame longer than sixteen bits, only the last sixteen bits are kept. `code_o` is still the ten bits ahead of the final two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| code_o | output | 10 | Latched DAC code |
| update_o | output | 1 | One-cycle pulse when `code_o` is loaded |

## Verification
The assertions assume that every serial clock phase and every select phase lasts longer than the synchronizer depth plus one system clock. They also assume that select changes only while the serial clock is low. Under these conditions, no serial edge and no select edge are seen in the same cycle, and the data bit is stable when its clock edge arrives. The stimulus holds each phase for four system clocks. It moves the select only after the serial clock has been low for at least four cycles.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned CODE_W  = 10;
  localparam int unsigned SUB_W   = 2;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned CODE_HI = CODE_W + SUB_W - 1;

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic sdi;
  } ser_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_V;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter logic RST_V = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_V;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         sel_hi_i,
  input  logic         bit_i,
  output logic [W-1:0] sh_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;
  logic         sh_en;

  always_comb begin
    sh_en = clear_i | (shift_i & ~sel_hi_i);
    sh_d  = clear_i ? '0 : {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign sh_o = sh_q;

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi_i && !clear_i) |=> $stable(sh_q));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (sh_q == '0));
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic              update_o
);
  ser_t raw, syn;
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic [FRAME_W-1:0] sh;
  logic [CODE_W-1:0]  code_q, code_d;
  logic               upd_q;

  assign raw = '{cs_n: cs_n_i, sclk: sclk_i, sdi: sdi_i};

  sdac_sync #(.W(3), .STAGES(SYNC_N), .RST_V(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  sdac_edge #(.RST_V(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(syn.cs_n),
    .rise_o(cs_rise), .fall_o(cs_fall));

  sdac_edge #(.RST_V(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(syn.sclk),
    .rise_o(sclk_rise), .fall_o(sclk_fall));

  sdac_shreg #(.W(FRAME_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .clear_i(cs_fall), .shift_i(sclk_rise),
    .sel_hi_i(syn.cs_n), .bit_i(syn.sdi), .sh_o(sh));

  always_comb code_d = sh[CODE_HI:SUB_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= cs_rise;
      if (cs_rise) code_q <= code_d;
    end
  end

  assign code_o   = code_q;
  assign update_o = upd_q;

  logic unused_ok;
  assign unused_ok = sclk_fall;

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !update_o |-> $stable(code_o));

  assert_no_mid_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !syn.cs_n |=> !update_o);
endmodule

// File: tb/sdac_rx_tb.sv
module sdac_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [9:0] code;
  logic       upd;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdac_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .code_o(code), .update_o(upd));

  always @(negedge clk) if (rst_n && upd) pulses++;

  // {length, frame bits (MSB first), expected code}
  localparam logic [47:0] VEC [8] = '{
    {6'd12, 32'({10'h155, 2'b01}), 10'h155},         // R2
    {6'd12, 32'({10'h2AA, 2'b10}), 10'h2AA},         // R2 R4
    {6'd16, 32'({4'hF, 10'h0F3, 2'b11}), 10'h0F3},  // R3
    {6'd16, 32'({4'h5, 10'h3FF, 2'b00}), 10'h3FF},  // R3
    {6'd5,  32'h1F, 10'h007},                        // R6 short after full
    {6'd12, 32'({10'h000, 2'b11}), 10'h000},         // R4
    {6'd20, 32'({8'hAB, 10'h21C, 2'b01}), 10'h21C}, // R9
    {6'd12, 32'({10'h3C1, 2'b11}), 10'h3C1}          // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int len, input logic [31:0] fr, input logic [9:0] prev);
    cs_n = 1'b0;
    wclk(4);
    for (int i = len - 1; i >= 0; i--) begin
      sdi = fr[i];
      wclk(4);
      sclk = 1'b1;
      wclk(4);
      sclk = 1'b0;
    end
    wclk(6);
    chk("R7 mid-frame hold", 32'(code), 32'(prev));
    cs_n = 1'b1;
  endtask

  initial begin
    wclk(200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] prev;
    int p0;
    wclk(3);
    chk("R1 reset code", 32'(code), 0);
    chk("R1 reset update", 32'(upd), 0);
    rst_n = 1'b1;
    wclk(10);
    chk("R1 after release", 32'(code), 0);
    chk("R1 no pulse", 32'(pulses), 0);
    prev = '0;

    for (int k = 0; k < 8; k++) begin
      p0 = pulses;
      send(int'(VEC[k][47:42]), VEC[k][41:10], prev);
      wclk(12);
      chk("R2/R3/R4/R6/R9 code", 32'(code), 32'(VEC[k][9:0]));
      chk("R8 one pulse", 32'(pulses - p0), 1);
      prev = VEC[k][9:0];
    end

    // R5: serial clock activity while select is high
    p0 = pulses;
    sdi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(8);
    chk("R5 code unchanged", 32'(code), 32'(prev));
    chk("R5 no pulse", 32'(pulses - p0), 0);

    // R8: pulse coincides with new code
    cs_n = 1'b0; wclk(4);
    for (int i = 11; i >= 0; i--) begin
      sdi = 1'(12'hA5C >> i);
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(6);
    cs_n = 1'b1;
    while (!upd) wclk(1);
    chk("R8 code with pulse", 32'(code), 32'h297);
    wclk(1);
    chk("R8 pulse width", 32'(upd), 0);

    // R1: reset during a frame
    cs_n = 1'b0; wclk(4);
    sdi = 1'b1; wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    rst_n = 1'b0; wclk(2);
    chk("R1 mid-frame reset", 32'(code), 0);
    cs_n = 1'b1; wclk(2);
    rst_n = 1'b1; wclk(10);
    chk("R1 quiet after reset", 32'(upd), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule